// File: doc/BRIEF.md
# Burst-8 Memory Command Issuer

This block sits between two show-ahead queues (buffered write packets and buffered read addresses) and the user port of a memory controller. On the controller side there is a 256-bit write data path, a single command/address/enable port and one ready signal that gates every transfer. Each access covers 512 bits, which is a burst of eight on a 64-bit memory. So each access carries exactly one command and one address, and its data moves as two 256-bit halves.

A write is sent in two phases. The first phase offers the low half on its own. The second phase offers the high half together with the write code and the address. While ready is low, the first phase lasts as long as needed, and any command already on the port is held unchanged. Reads are sent straight from the read-address queue, one per cycle while ready stays high. Each read is sent only when the downstream read-data queue has room for its packet. Returned data arrives as two 256-bit beats, low half first. The two beats are joined and pushed as one 512-bit entry, in issue order. A `done` flag tells the front end that both queues are empty and no read is still outstanding.

Top module: `b8_cmd_issuer`

## Requirements
- R1: After reset the block asserts no enable, no write-data valid, no queue pop and no push, and `done` is high when both input queues are empty.
- R2: A write starts with a phase that offers the low half (`wq_data[255:0]`) with `mc_wen`=1 and `mc_wend`=0, and with no command enable. This phase and its data are held for as long as `mc_rdy` is low.
- R3: The write command (code 3'b000) is enabled only after the low half has been accepted. It goes out with the high half (`wq_data[511:256]`), `mc_wend`=1 and the packet's address.
- R4: While `mc_en` is high and `mc_rdy` is low, the enable, command code and address stay unchanged into the next cycle.
- R5: The write queue is popped exactly once per accepted write command, in the same cycle as that acceptance.
- R6: Read commands use code 3'b001 and the addresses in queue order. They are issued on consecutive cycles while `mc_rdy` stays high, and once every two cycles when `mc_rdy` alternates.
- R7: A read is enabled only while the number of outstanding reads is below `rdq_free`, so the read-data queue never receives a push when it is full.
- R8: Returned beats are paired, the first beat forming bits 255:0 and the second bits 511:256. One push per pair happens in the cycle of the second beat, in issue order.
- R9: When the block is idle and both queues hold entries, writes are sent before reads.
- R10: `done` is high only when both queues are empty, the sequencer is idle and no read data is outstanding. While `done` is high, no enable or write-data valid is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wq_empty | input | 1 | Write queue holds no packet |
| wq_addr | input | AW (28) | Address of the head write packet |
| wq_data | input | 2*HW (512) | Data of the head write packet |
| wq_pop | output | 1 | Remove head write packet |
| ra_empty | input | 1 | Read-address queue is empty |
| ra_addr | input | AW (28) | Head read address |
| ra_pop | output | 1 | Remove head read address |
| rdq_free | input | FW (4) | Free entries in the read-data queue |
| rdq_push | output | 1 | Push one assembled read packet |
| rdq_data | output | 2*HW (512) | Assembled read packet |
| mc_cmd | output | 3 | Command code: 3'b000 write, 3'b001 read |
| mc_addr | output | AW (28) | Command address |
| mc_en | output | 1 | Command enable |
| mc_rdy | input | 1 | Controller accepts command and write data |
| mc_wdata | output | HW (256) | Write data half |
| mc_wen | output | 1 | Write data half valid |
| mc_wend | output | 1 | Marks the high (last) half |
| mc_rvalid | input | 1 | Read data beat valid |
| mc_rdata | input | HW (256) | Read data beat |
| done | output | 1 | Both queues empty and nothing outstanding |

## Verification
Every controller-side output is combinational from the sequencer state and the queue heads. A handshake therefore takes effect at the edge that follows the cycle in which enable (or write valid) and ready are both high. The queue pop comes in that same cycle, and the next entry is visible one cycle later. The bench drives all inputs just after the falling edge. It waits one time step and then reads the outputs that the next rising edge will act on, so each result is checked in the cycle it becomes due. Hold checks compare against values taken one cycle earlier. The two-beat push is checked in the cycle of the second beat, against a scoreboard queue filled by the load tasks.

// File: rtl/b8_pkg.sv
`timescale 1ns/1ps
package b8_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WLO  = 2'd1,
    ST_WHI  = 2'd2,
    ST_RD   = 2'd3
  } iss_state_e;

  localparam logic [2:0] CMD_WR = 3'b000;
  localparam logic [2:0] CMD_RD = 3'b001;

  // A new read may go out only while outstanding reads leave room downstream.
  function automatic logic credit_ok(input int unsigned inflight,
                                     input int unsigned free_slots);
    return inflight < free_slots;
  endfunction

  function automatic int unsigned next_inflight(input int unsigned cur,
                                                input logic issued,
                                                input logic pushed);
    return cur + int'(issued) - int'(pushed);
  endfunction

endpackage

// File: rtl/b8_issue_fsm.sv
`timescale 1ns/1ps
module b8_issue_fsm
  import b8_pkg::*;
#(
  parameter int AW = 28,
  parameter int HW = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wq_empty,
  input  logic [AW-1:0]   wq_addr,
  input  logic [2*HW-1:0] wq_data,
  input  logic            ra_empty,
  input  logic [AW-1:0]   ra_addr,
  input  logic            rd_credit,
  input  logic            mc_rdy,
  output logic            wq_pop,
  output logic            ra_pop,
  output logic            mc_en,
  output logic [2:0]      mc_cmd,
  output logic [AW-1:0]   mc_addr,
  output logic            mc_wen,
  output logic            mc_wend,
  output logic [HW-1:0]   mc_wdata,
  output logic            rd_issue,
  output logic            seq_idle
);

  iss_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    wq_pop   = 1'b0;
    ra_pop   = 1'b0;
    mc_en    = 1'b0;
    mc_cmd   = CMD_WR;
    mc_addr  = '0;
    mc_wen   = 1'b0;
    mc_wend  = 1'b0;
    mc_wdata = '0;
    state_d  = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!wq_empty)      state_d = ST_WLO;
        else if (!ra_empty) state_d = ST_RD;
      end
      ST_WLO: begin
        mc_wen   = 1'b1;
        mc_wdata = wq_data[HW-1:0];
        if (mc_rdy) state_d = ST_WHI;
      end
      ST_WHI: begin
        mc_wen   = 1'b1;
        mc_wend  = 1'b1;
        mc_wdata = wq_data[2*HW-1:HW];
        mc_en    = 1'b1;
        mc_cmd   = CMD_WR;
        mc_addr  = wq_addr;
        wq_pop   = mc_rdy;
        if (mc_rdy) state_d = ST_IDLE;
      end
      ST_RD: begin
        mc_en   = !ra_empty && rd_credit;
        mc_cmd  = CMD_RD;
        mc_addr = ra_addr;
        ra_pop  = mc_en && mc_rdy;
        if (ra_empty) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rd_issue = ra_pop;
  assign seq_idle = (state_q == ST_IDLE);

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mc_en && !mc_rdy |=> mc_en && $stable(mc_addr) && $stable(mc_cmd)); // R4

  AST_LO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mc_wen && !mc_wend && !mc_rdy |=> mc_wen && !mc_wend && $stable(mc_wdata)); // R2

  AST_WR_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_en) && (mc_cmd == CMD_WR) |-> $past(mc_wen && !mc_wend && mc_rdy)); // R3

  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wq_pop, ra_pop})); // R5

endmodule

// File: rtl/b8_rd_credit.sv
`timescale 1ns/1ps
module b8_rd_credit
  import b8_pkg::*;
#(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issued,
  input  logic          pushed,
  output logic [FW-1:0] inflight
);

  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= FW'(next_inflight(int'(cnt_q), issued, pushed));
  end

  assign inflight = cnt_q;

  AST_PUSH_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    pushed |-> (cnt_q != '0)); // R8

endmodule

// File: rtl/b8_rd_pack.sv
`timescale 1ns/1ps
module b8_rd_pack #(
  parameter int HW = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat_valid,
  input  logic [HW-1:0]   beat_data,
  output logic            pkt_push,
  output logic [2*HW-1:0] pkt_data
);

  logic          second_q;
  logic [HW-1:0] low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      low_q    <= '0;
    end else if (beat_valid) begin
      second_q <= !second_q;
      if (!second_q) low_q <= beat_data;
    end
  end

  assign pkt_push = beat_valid && second_q;
  assign pkt_data = {beat_data, low_q};

  AST_PAIR_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_push |=> !pkt_push); // R8

endmodule

// File: rtl/b8_cmd_issuer.sv
`timescale 1ns/1ps
module b8_cmd_issuer
  import b8_pkg::*;
#(
  parameter int AW = 28,
  parameter int HW = 256,
  parameter int FW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wq_empty,
  input  logic [AW-1:0]   wq_addr,
  input  logic [2*HW-1:0] wq_data,
  output logic            wq_pop,
  input  logic            ra_empty,
  input  logic [AW-1:0]   ra_addr,
  output logic            ra_pop,
  input  logic [FW-1:0]   rdq_free,
  output logic            rdq_push,
  output logic [2*HW-1:0] rdq_data,
  output logic [2:0]      mc_cmd,
  output logic [AW-1:0]   mc_addr,
  output logic            mc_en,
  input  logic            mc_rdy,
  output logic [HW-1:0]   mc_wdata,
  output logic            mc_wen,
  output logic            mc_wend,
  input  logic            mc_rvalid,
  input  logic [HW-1:0]   mc_rdata,
  output logic            done
);

  logic          rd_issue;
  logic          seq_idle;
  logic          rd_credit;
  logic [FW-1:0] inflight;

  assign rd_credit = credit_ok(int'(inflight), int'(rdq_free));

  b8_issue_fsm #(.AW(AW), .HW(HW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wq_empty (wq_empty),
    .wq_addr  (wq_addr),
    .wq_data  (wq_data),
    .ra_empty (ra_empty),
    .ra_addr  (ra_addr),
    .rd_credit(rd_credit),
    .mc_rdy   (mc_rdy),
    .wq_pop   (wq_pop),
    .ra_pop   (ra_pop),
    .mc_en    (mc_en),
    .mc_cmd   (mc_cmd),
    .mc_addr  (mc_addr),
    .mc_wen   (mc_wen),
    .mc_wend  (mc_wend),
    .mc_wdata (mc_wdata),
    .rd_issue (rd_issue),
    .seq_idle (seq_idle)
  );

  b8_rd_credit #(.FW(FW)) u_credit (
    .clk     (clk),
    .rst_n   (rst_n),
    .issued  (rd_issue),
    .pushed  (rdq_push),
    .inflight(inflight)
  );

  b8_rd_pack #(.HW(HW)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_valid(mc_rvalid),
    .beat_data (mc_rdata),
    .pkt_push  (rdq_push),
    .pkt_data  (rdq_data)
  );

  assign done = seq_idle && wq_empty && ra_empty && (inflight == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    mc_en && (mc_cmd == CMD_RD) |-> (inflight < rdq_free)); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mc_en && !mc_wen); // R10

endmodule

// File: tb/b8_cmd_issuer_test.sv
`timescale 1ns/1ps
module b8_cmd_issuer_test;
  localparam int AW = 28;
  localparam int HW = 256;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            wq_empty = 1'b1;
  logic [AW-1:0]   wq_addr = '0;
  logic [2*HW-1:0] wq_data = '0;
  logic            wq_pop;
  logic            ra_empty = 1'b1;
  logic [AW-1:0]   ra_addr = '0;
  logic            ra_pop;
  logic [FW-1:0]   rdq_free = '0;
  logic            rdq_push;
  logic [2*HW-1:0] rdq_data;
  logic [2:0]      mc_cmd;
  logic [AW-1:0]   mc_addr;
  logic            mc_en;
  logic            mc_rdy = 1'b0;
  logic [HW-1:0]   mc_wdata;
  logic            mc_wen;
  logic            mc_wend;
  logic            mc_rvalid = 1'b0;
  logic [HW-1:0]   mc_rdata = '0;
  logic            done;

  b8_cmd_issuer #(.AW(AW), .HW(HW), .FW(FW)) uut (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // models and scoreboard
  logic [AW-1:0]   wq_a[$];
  logic [2*HW-1:0] wq_d[$];
  logic [AW-1:0]   ra_q[$];
  logic [AW-1:0]   exp_wa[$];
  logic [2*HW-1:0] exp_wd[$];
  logic [AW-1:0]   exp_ra[$];
  logic [2*HW-1:0] exp_rd[$];
  logic [HW-1:0]   beat_q[$];
  int rdq_count = 0, rdq_cap = 15, drain_per = 1, outstanding = 0;
  int rdy_mode = 0, exp_gap = 0, last_rd = -1, cyc = 0;
  bit first_pending = 0;
  // handshakes seen before an edge, applied after it
  bit p_wq_pop = 0, p_ra_pop = 0, p_beat = 0, p_push = 0, p_rd = 0;
  logic [AW-1:0] p_rd_addr = '0;
  // values at the previous edge
  bit pv_en = 0, pv_rdy = 0, pv_lo = 0;
  logic [AW-1:0] pv_addr = '0;
  logic [2:0] pv_cmd = '0;
  logic [HW-1:0] pv_wdata = '0;
  bit lo_taken = 0;
  logic [HW-1:0] lo_data = '0;

  function automatic logic [2*HW-1:0] mkdata(input int seed);
    logic [2*HW-1:0] d;
    for (int i = 0; i < 2*HW/32; i++) d[i*32 +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(i * 7919);
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [2*HW-1:0] act,
                       input logic [2*HW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic load_write(input int addr, input int seed);
    wq_a.push_back(AW'(addr)); wq_d.push_back(mkdata(seed));
    exp_wa.push_back(AW'(addr)); exp_wd.push_back(mkdata(seed));
  endtask

  task automatic load_read(input int addr);
    ra_q.push_back(AW'(addr)); exp_ra.push_back(AW'(addr));
    exp_rd.push_back(mkdata(addr + 1000));
  endtask

  task automatic cycle();
    logic [2*HW-1:0] rb;
    @(negedge clk);
    cyc++;
    if (p_wq_pop) begin void'(wq_a.pop_front()); void'(wq_d.pop_front()); end
    if (p_ra_pop) void'(ra_q.pop_front());
    if (p_beat) void'(beat_q.pop_front());
    if (p_push) begin rdq_count++; outstanding--; end
    if (p_rd) begin
      rb = mkdata(int'(p_rd_addr) + 1000);
      beat_q.push_back(rb[HW-1:0]); beat_q.push_back(rb[2*HW-1:HW]);
    end
    if (drain_per > 0 && rdq_count > 0 && (cyc % drain_per) == 0) rdq_count--;
    wq_empty = (wq_a.size() == 0);
    wq_addr  = wq_empty ? '0 : wq_a[0];
    wq_data  = wq_empty ? '0 : wq_d[0];
    ra_empty = (ra_q.size() == 0);
    ra_addr  = ra_empty ? '0 : ra_q[0];
    rdq_free = FW'(rdq_cap - rdq_count);
    case (rdy_mode)
      0: mc_rdy = 1'b1;
      1: mc_rdy = cyc[0];
      default: mc_rdy = ((cyc * 7) % 5) > 1;
    endcase
    mc_rvalid = (beat_q.size() > 0) && (cyc % 3 != 0);
    mc_rdata  = mc_rvalid ? beat_q[0] : '0;
    #1;
    if (rst_n) begin
      if (pv_en && !pv_rdy)
        check(mc_en && mc_addr == pv_addr && mc_cmd == pv_cmd, "R4 hold", {mc_en, mc_addr}, {1'b1, pv_addr});
      if (pv_lo && !pv_rdy)
        check(mc_wen && !mc_wend && mc_wdata == pv_wdata, "R2 low half stretch", mc_wdata, pv_wdata);
      if (mc_wen && !mc_wend && mc_rdy) begin lo_taken = 1; lo_data = mc_wdata; end
      if (mc_en && mc_rdy && first_pending) begin
        check(mc_cmd == 3'b000, "R9 write first", mc_cmd, 3'b000);
        first_pending = 0;
      end
      if (mc_en && mc_rdy && mc_cmd == 3'b000) begin
        check(lo_taken && mc_wen && mc_wend, "R3 low half before command", {lo_taken, mc_wend}, 2'b11);
        check(exp_wa.size() > 0 && mc_addr == exp_wa[0] && {mc_wdata, lo_data} == exp_wd[0],
              "R3 write packet", {mc_addr, mc_wdata, lo_data}, exp_wd.size() > 0 ? exp_wd[0] : '0);
        check(wq_pop, "R5 pop with write", wq_pop, 1);
        if (exp_wa.size() > 0) begin void'(exp_wa.pop_front()); void'(exp_wd.pop_front()); end
        lo_taken = 0;
      end else if (wq_pop) check(0, "R5 stray pop", wq_pop, 0);
      if (mc_en && mc_rdy && mc_cmd != 3'b000) begin
        check(mc_cmd == 3'b001 && exp_ra.size() > 0 && mc_addr == exp_ra[0], "R6 read address",
              {mc_cmd, mc_addr}, exp_ra.size() > 0 ? {3'b001, exp_ra[0]} : '0);
        check(outstanding + rdq_count < rdq_cap, "R7 read credit", outstanding + rdq_count, rdq_cap);
        if (exp_gap != 0 && last_rd >= 0)
          check(cyc - last_rd == exp_gap, "R6 issue rate", cyc - last_rd, exp_gap);
        last_rd = cyc;
        outstanding++;
        if (exp_ra.size() > 0) void'(exp_ra.pop_front());
      end
      if (rdq_push) begin
        check(exp_rd.size() > 0 && rdq_data == exp_rd[0], "R8 read packet", rdq_data,
              exp_rd.size() > 0 ? exp_rd[0] : '0);
        check(rdq_count < rdq_cap, "R7 no overflow", rdq_count, rdq_cap);
        if (exp_rd.size() > 0) void'(exp_rd.pop_front());
      end
    end
    p_wq_pop = wq_pop; p_ra_pop = ra_pop; p_beat = mc_rvalid; p_push = rdq_push;
    p_rd = mc_en && mc_rdy && mc_cmd == 3'b001; p_rd_addr = mc_addr;
    pv_en = mc_en; pv_rdy = mc_rdy; pv_addr = mc_addr; pv_cmd = mc_cmd;
    pv_lo = mc_wen && !mc_wend; pv_wdata = mc_wdata;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    repeat (3) cycle();
    while (!done && n < 3000) begin cycle(); n++; end
    check(done, {"R10 done ", tag}, done, 1);
    check(exp_wa.size() == 0 && exp_ra.size() == 0 && exp_rd.size() == 0,
          {"R10 scoreboard drained ", tag}, exp_wa.size() + exp_ra.size() + exp_rd.size(), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 150000);
    total++; bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) cycle();
    rst_n = 1'b1;
    cycle();
    // R1: reset state
    check(!mc_en && !mc_wen && !wq_pop && !ra_pop && !rdq_push, "R1 idle outputs",
          {mc_en, mc_wen, wq_pop, ra_pop, rdq_push}, 0);
    check(done, "R1 done after reset", done, 1);

    // writes under an irregular ready pattern
    rdy_mode = 2;
    for (int i = 0; i < 6; i++) load_write(i * 8, i + 11);
    cycle();
    check(!done, "R10 busy with writes", done, 0);
    wait_done("writes");

    // reads back to back
    rdy_mode = 0; exp_gap = 1; last_rd = -1; rdq_cap = 15; drain_per = 1; rdq_count = 0;
    for (int i = 0; i < 6; i++) load_read(i * 8);
    wait_done("fast reads");

    // reads against an alternating ready
    rdy_mode = 1; exp_gap = 2; last_rd = -1;
    for (int i = 0; i < 5; i++) load_read(100 + i);
    wait_done("alternating reads");

    // reads limited by read-data queue space
    rdy_mode = 0; exp_gap = 0; rdq_cap = 2; drain_per = 7; rdq_count = 0;
    for (int i = 0; i < 6; i++) load_read(200 + i);
    wait_done("credit reads");

    // writes and reads loaded together
    rdy_mode = 2; rdq_cap = 4; drain_per = 2; rdq_count = 0; first_pending = 1;
    for (int i = 0; i < 3; i++) begin load_write(300 + i, 50 + i); load_read(400 + i); end
    wait_done("mixed");
    check(!first_pending, "R9 first command seen", first_pending, 0);

    summary();
  end
endmodule